// File: doc/BRIEF.md
# Pin-Borrowing Parallel Scan Chain

This block adds a simple test access path to a memory-style device without a JTAG TAP controller. One dedicated enable pin puts the device into scan mode. After that, four ordinary functional pins take on scan duties. The chip-select pin becomes the scan clock. The reset pin becomes the shift control. The mode pin becomes an active-low output enable. The write-strobe pad turns around and drives serial scan data out.

Each observed pin has its own flop in the chain. A rising scan-clock edge either loads all flops at once from the observed pins, or moves the chain one place toward the output. Chain positions that stand for reserved balls always load zero. The scan-clock and shift pins are brought into the block clock domain through a synchronizer, and their edges are detected there.

Scan mode is sticky. Once entered, it can be left only by a power-on reset. While scan mode is active, the core sees its command pins held inactive, so that scan-clock toggles on the chip-select pin never become memory commands.

Top module: `pbscan_top`

## Requirements
- R1: After power-on reset (`por_n` low), scan mode is inactive. Every chain flop is 0, `wstb_pad_oe_o` is 0 and `wstb_pad_o` is 0.
- R2: While `pin_scan_en` has never been high since reset, `core_cs_n_o`, `core_rst_o`, `core_mode_o` and `core_wstb_o` follow their pins. Toggles on `pin_cs_n` leave the chain unchanged and `wstb_pad_oe_o` stays 0.
- R3: A high level on `pin_scan_en` makes `scan_active_o` 1 at once. The mode latch sets on the next clock. It stays set after `pin_scan_en` returns low, until `por_n` is asserted.
- R4: While `scan_active_o` is 1, the core outputs are held inactive: `core_cs_n_o`=1, `core_rst_o`=0, `core_mode_o`=0, `core_wstb_o`=0.
- R5: Both `pin_cs_n` (scan clock) and `pin_rst` (shift control) pass through a SYNC_STAGES-deep synchronizer. With the default depth of 2, a scan-clock rise set up before clock edge E1 updates the chain at edge E3 and not earlier.
- R6: A scan-clock rise with `pin_rst` low loads chain position i from `probe_i[i]`. Positions whose ZERO_MASK bit is set load 0 instead. The default mask sets positions 0, 5 and 10.
- R7: A scan-clock rise with `pin_rst` high moves position i to position i+1 and loads 0 into position 0. Position CHAIN_LEN-1 is the serial output.
- R8: `wstb_pad_o` shows chain position CHAIN_LEN-1 at all times in scan mode. After a capture, the highest bit is visible before any shift edge. After CHAIN_LEN shifts, the output is 0.
- R9: `wstb_pad_oe_o` is 1 only when scan mode is active and `pin_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample all pins |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_scan_en | input | 1 | Dedicated scan-mode enable pin |
| pin_cs_n | input | 1 | Chip select; scan clock in scan mode |
| pin_rst | input | 1 | Reset pin; shift control in scan mode |
| pin_mode | input | 1 | Mode pin; active-low scan output enable in scan mode |
| pin_wstb_i | input | 1 | Write strobe received from the pad in functional mode |
| probe_i | input | CHAIN_LEN | Values of the observed pins, one per chain position |
| scan_active_o | output | 1 | Scan mode in effect |
| core_cs_n_o | output | 1 | Chip select forwarded to the core |
| core_rst_o | output | 1 | Reset forwarded to the core |
| core_mode_o | output | 1 | Mode pin forwarded to the core |
| core_wstb_o | output | 1 | Write strobe forwarded to the core |
| wstb_pad_o | output | 1 | Serial scan data driven onto the write-strobe pad |
| wstb_pad_oe_o | output | 1 | Pad driver enable for scan data |

## Verification
The hardest condition to reach from the ports is proof that scan-clock toggles made before scan entry had no effect. The chain starts at zero, so an ignored capture looks the same as no capture at all. The stimulus therefore presents an all-ones pattern and pulses the chip-select pin while the enable is low. Only then does it enter scan mode and read the output bit, before any fresh capture. A second hard case is the exact synchronizer latency. It is checked by sampling the output one clock before, and again at, the edge where a shift must land.

// File: rtl/pbscan_pkg.sv
package pbscan_pkg;

    // Operation applied to the chain on a given block clock
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } chain_op_e;

endpackage

// File: rtl/pbscan_mode_ctl.sv
module pbscan_mode_ctl
    import pbscan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      por_n,
    input  logic      scan_en_i,
    input  logic      sck_pin_i,
    input  logic      shift_pin_i,
    output logic      mode_o,
    output chain_op_e op_o
);

    typedef struct packed {
        logic                   mode;
        logic [SYNC_STAGES-1:0] sck;
        logic [SYNC_STAGES-1:0] sh;
        logic                   sck_last;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       sck_now;
    logic       sh_now;
    logic       sck_rise;

    always_comb begin
        st_d      = st_q;
        sck_now   = st_q.sck[SYNC_STAGES-1];
        sh_now    = st_q.sh[SYNC_STAGES-1];
        sck_rise  = sck_now & ~st_q.sck_last;

        // sticky latch: only power-on reset clears it
        st_d.mode     = st_q.mode | scan_en_i;
        st_d.sck      = {st_q.sck[SYNC_STAGES-2:0], sck_pin_i};
        st_d.sh       = {st_q.sh[SYNC_STAGES-2:0], shift_pin_i};
        st_d.sck_last = sck_now;

        op_o = OP_HOLD;
        if (st_q.mode && sck_rise) begin
            op_o = sh_now ? OP_SHIFT : OP_CAPTURE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    // R3
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        st_q.mode |=> st_q.mode);

    // R2
    no_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!st_q.mode && !scan_en_i) |=> !st_q.mode);

    // R2
    op_needs_mode_chk: assert property (@(posedge clk) disable iff (!por_n)
        (op_o != OP_HOLD) |-> st_q.mode);

endmodule

// File: rtl/pbscan_chain.sv
module pbscan_chain
    import pbscan_pkg::*;
#(
    parameter int                  CHAIN_LEN = 16,
    parameter logic [CHAIN_LEN-1:0] ZERO_MASK = 16'h0421
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  chain_op_e            op_i,
    input  logic [CHAIN_LEN-1:0] probe_i,
    output logic                 tail_o
);

    logic [CHAIN_LEN-1:0] chain_d, chain_q;
    logic [CHAIN_LEN-1:0] cap_val;

    // reserved positions are tied to zero
    for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_cap
        if (ZERO_MASK[g]) begin : g_zero
            assign cap_val[g] = 1'b0;
        end else begin : g_live
            assign cap_val[g] = probe_i[g];
        end
    end

    always_comb begin
        chain_d = chain_q;
        case (op_i)
            OP_CAPTURE: chain_d = cap_val;
            OP_SHIFT:   chain_d = {chain_q[CHAIN_LEN-2:0], 1'b0};
            default:    chain_d = chain_q;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign tail_o = chain_q[CHAIN_LEN-1];

    // R6
    cap_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (op_i == OP_CAPTURE) |=> ((chain_q & ZERO_MASK) == '0));

    // R7
    shift_move_chk: assert property (@(posedge clk) disable iff (!por_n)
        (op_i == OP_SHIFT) |=>
            (chain_q[CHAIN_LEN-1:1] == $past(chain_q[CHAIN_LEN-2:0])) && !chain_q[0]);

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
        (op_i == OP_HOLD) |=> $stable(chain_q));

endmodule

// File: rtl/pbscan_pinmux.sv
module pbscan_pinmux (
    input  logic scan_active_i,
    input  logic pin_cs_n,
    input  logic pin_rst,
    input  logic pin_mode,
    input  logic pin_wstb_i,
    input  logic tail_i,
    output logic core_cs_n_o,
    output logic core_rst_o,
    output logic core_mode_o,
    output logic core_wstb_o,
    output logic pad_o,
    output logic pad_oe_o
);

    always_comb begin
        if (scan_active_i) begin
            core_cs_n_o = 1'b1;
            core_rst_o  = 1'b0;
            core_mode_o = 1'b0;
            core_wstb_o = 1'b0;
            pad_o       = tail_i;
            pad_oe_o    = ~pin_mode;
        end else begin
            core_cs_n_o = pin_cs_n;
            core_rst_o  = pin_rst;
            core_mode_o = pin_mode;
            core_wstb_o = pin_wstb_i;
            pad_o       = 1'b0;
            pad_oe_o    = 1'b0;
        end
    end

endmodule

// File: rtl/pbscan_top.sv
module pbscan_top
    import pbscan_pkg::*;
#(
    parameter int                  CHAIN_LEN   = 16,
    parameter logic [CHAIN_LEN-1:0] ZERO_MASK   = 16'h0421,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 pin_scan_en,
    input  logic                 pin_cs_n,
    input  logic                 pin_rst,
    input  logic                 pin_mode,
    input  logic                 pin_wstb_i,
    input  logic [CHAIN_LEN-1:0] probe_i,
    output logic                 scan_active_o,
    output logic                 core_cs_n_o,
    output logic                 core_rst_o,
    output logic                 core_mode_o,
    output logic                 core_wstb_o,
    output logic                 wstb_pad_o,
    output logic                 wstb_pad_oe_o
);

    logic      mode_q;
    chain_op_e op;
    logic      tail;

    pbscan_mode_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
        .clk        (clk),
        .por_n      (por_n),
        .scan_en_i  (pin_scan_en),
        .sck_pin_i  (pin_cs_n),
        .shift_pin_i(pin_rst),
        .mode_o     (mode_q),
        .op_o       (op)
    );

    pbscan_chain #(.CHAIN_LEN(CHAIN_LEN), .ZERO_MASK(ZERO_MASK)) u_chain (
        .clk    (clk),
        .por_n  (por_n),
        .op_i   (op),
        .probe_i(probe_i),
        .tail_o (tail)
    );

    // enable pin gates the mux immediately; latch keeps it afterwards
    assign scan_active_o = mode_q | pin_scan_en;

    pbscan_pinmux u_mux (
        .scan_active_i(scan_active_o),
        .pin_cs_n     (pin_cs_n),
        .pin_rst      (pin_rst),
        .pin_mode     (pin_mode),
        .pin_wstb_i   (pin_wstb_i),
        .tail_i       (tail),
        .core_cs_n_o  (core_cs_n_o),
        .core_rst_o   (core_rst_o),
        .core_mode_o  (core_mode_o),
        .core_wstb_o  (core_wstb_o),
        .pad_o        (wstb_pad_o),
        .pad_oe_o     (wstb_pad_oe_o)
    );

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
        wstb_pad_oe_o |-> (scan_active_o && !pin_mode));

    // R4
    core_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        scan_active_o |-> (core_cs_n_o && !core_rst_o && !core_mode_o && !core_wstb_o));

    // R3
    active_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        mode_q |=> scan_active_o);

endmodule

// File: tb/pbscan_top_bench.sv
module pbscan_top_bench;

    localparam int          L    = 16;
    localparam logic [L-1:0] MASK = 16'h0421;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         pin_scan_en = 1'b0, pin_cs_n = 1'b1, pin_rst = 1'b0;
    logic         pin_mode = 1'b1, pin_wstb_i = 1'b0;
    logic [L-1:0] probe_i = '0;
    logic         scan_active_o, core_cs_n_o, core_rst_o, core_mode_o, core_wstb_o;
    logic         wstb_pad_o, wstb_pad_oe_o;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pbscan_top u_pbscan_top (
        .clk(clk), .por_n(por_n), .pin_scan_en(pin_scan_en), .pin_cs_n(pin_cs_n),
        .pin_rst(pin_rst), .pin_mode(pin_mode), .pin_wstb_i(pin_wstb_i),
        .probe_i(probe_i), .scan_active_o(scan_active_o), .core_cs_n_o(core_cs_n_o),
        .core_rst_o(core_rst_o), .core_mode_o(core_mode_o), .core_wstb_o(core_wstb_o),
        .wstb_pad_o(wstb_pad_o), .wstb_pad_oe_o(wstb_pad_oe_o)
    );

    // {probe pattern, pin_mode during readout}
    localparam logic [L:0] VEC [4] = '{
        {16'hFFFF, 1'b0}, {16'hA5C3, 1'b0}, {16'h0001, 1'b1}, {16'h8421, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sck_pulse(input logic shift);
        pin_rst  = shift;
        pin_cs_n = 1'b1;
        repeat (4) tick();
        pin_cs_n = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        pin_cs_n = 1'b0;
        repeat (3) tick();
        // R1 reset state
        chk(!scan_active_o, "R1 mode", scan_active_o, 0);
        chk(!wstb_pad_oe_o && !wstb_pad_o, "R1 pad", {wstb_pad_oe_o, wstb_pad_o}, 0);
        por_n = 1'b1;
        tick();

        // R2 pass-through and ignored scan clocks
        pin_cs_n = 1'b0; pin_rst = 1'b1; pin_mode = 1'b1; pin_wstb_i = 1'b1;
        #1;
        chk({core_cs_n_o, core_rst_o, core_mode_o, core_wstb_o} == 4'b0111,
            "R2 passthru", {core_cs_n_o, core_rst_o, core_mode_o, core_wstb_o}, 4'b0111);
        probe_i = 16'hFFFF;
        sck_pulse(1'b0);
        sck_pulse(1'b0);
        chk(!scan_active_o, "R2 no entry", scan_active_o, 0);
        chk(!wstb_pad_oe_o, "R2 oe", wstb_pad_oe_o, 0);

        // R3 entry
        pin_mode = 1'b0;
        pin_scan_en = 1'b1;
        #1;
        chk(scan_active_o, "R3 immediate", scan_active_o, 1);
        tick();
        pin_scan_en = 1'b0;
        repeat (5) tick();
        chk(scan_active_o, "R3 sticky", scan_active_o, 1);
        // R2: earlier pulses must not have captured
        chk(wstb_pad_o == 1'b0, "R2 chain untouched", wstb_pad_o, 0);

        // R4 core held inactive
        pin_cs_n = 1'b0; pin_rst = 1'b1; pin_mode = 1'b1; pin_wstb_i = 1'b1;
        #1;
        chk({core_cs_n_o, core_rst_o, core_mode_o, core_wstb_o} == 4'b1000,
            "R4 quiet", {core_cs_n_o, core_rst_o, core_mode_o, core_wstb_o}, 4'b1000);
        pin_rst = 1'b0;
        tick();

        // R6 R7 R8 R9 vector table
        for (int v = 0; v < 4; v++) begin
            logic [L-1:0] exp;
            exp = VEC[v][L:1] & ~MASK;
            probe_i  = VEC[v][L:1];
            pin_mode = VEC[v][0];
            sck_pulse(1'b0);
            probe_i = ~VEC[v][L:1];
            chk(wstb_pad_oe_o == !VEC[v][0], "R9 oe", wstb_pad_oe_o, !VEC[v][0]);
            for (int k = 0; k < L; k++) begin
                chk(wstb_pad_o == exp[L-1-k], "R6 R8 serial bit", wstb_pad_o, exp[L-1-k]);
                sck_pulse(1'b1);
            end
            chk(wstb_pad_o == 1'b0, "R7 zero fill", wstb_pad_o, 0);
        end

        // R5 synchronizer latency
        pin_mode = 1'b0;
        probe_i  = 16'h8000;
        sck_pulse(1'b0);
        chk(wstb_pad_o == 1'b1, "R5 preload", wstb_pad_o, 1);
        pin_rst  = 1'b1;
        pin_cs_n = 1'b1;
        tick(); tick();
        chk(wstb_pad_o == 1'b1, "R5 not yet", wstb_pad_o, 1);
        tick();
        chk(wstb_pad_o == 1'b0, "R5 lands E3", wstb_pad_o, 0);
        pin_cs_n = 1'b0;
        repeat (4) tick();

        // R1 power-on reset clears sticky mode
        por_n = 1'b0;
        tick();
        por_n = 1'b1;
        pin_cs_n = 1'b0; pin_rst = 1'b0; pin_mode = 1'b1; pin_wstb_i = 1'b0;
        tick();
        chk(!scan_active_o, "R1 R3 cleared", scan_active_o, 0);
        chk({core_cs_n_o, core_mode_o} == 2'b01, "R1 passthru after por",
            {core_cs_n_o, core_mode_o}, 2'b01);
        pin_scan_en = 1'b1;
        pin_mode = 1'b0;
        tick();
        chk(wstb_pad_o == 1'b0, "R1 chain zero", wstb_pad_o, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule